// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block sits in front of a memory port and handles the fast path of virtual-to-physical translation. It accepts one request at a time. A request carries a virtual address, an access size and an access kind: instruction fetch, data load or data store. The block checks alignment for data accesses first. It then looks the virtual page up in a direct-mapped table of translations. The answer is a physical address on a hit, a misalignment exception for data accesses whose address is not a multiple of the size, or a miss request to an external page walker.

Each table slot holds one physical page base and three independent virtual-page tags with their own valid bits, one for each access kind. The same page can therefore be usable for loads but not yet for stores. The walker answers a miss through a refill port, which writes one kind's tag and the page base into a slot. It then pulses a done strobe, and the block repeats the lookup. A flush input empties the whole table.

Top module: `xlat_cache`

## Requirements
- R1: A load (reqType 1) or store (reqType 2) whose address is not a multiple of its size raises a response with rspKind 1 (load) or 2 (store) and never raises missValid. Size codes 0..3 mean 1, 2, 4 and 8 bytes. The response arrives two clock edges after the accepting edge.
- R2: A fetch (reqType 0) is never alignment-checked, whatever its address and size code. reqType 3 is handled as a load.
- R3: The virtual page number is the address bits above bit 11, and the slot index is its low 8 bits. A hit requires that the requested kind's stored tag equals the full page number, so two pages 256 apart evict each other.
- R4: A hit gives rspKind 0 and a rspPaddr made of the slot's page base above bit 11 and the request's low 12 address bits.
- R5: The tags of the three kinds are independent: a refill for one kind does not make another kind hit.
- R6: A refill whose page base equals the slot's stored base keeps the other two kinds' valid bits. A refill with a different base clears them.
- R7: A miss raises missValid together with missVpn and missType, all held stable until fillDone. The lookup then repeats and responds two edges after the done edge.
- R8: A one-cycle flush pulse invalidates every kind in every slot, and the flush wins over a refill in the same cycle.
- R9: After reset every slot is invalid, reqReady is 1, and rspValid and missValid are 0.
- R10: rspValid is a one-cycle pulse. reqReady is 0 from the accepting edge until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all table slots |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted on this edge |
| reqVaddr | input | VA_W | Virtual address |
| reqSize | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqType | input | 2 | 0 fetch, 1 load, 2 store |
| rspValid | output | 1 | Response pulse |
| rspKind | output | 2 | 0 hit, 1 load misaligned, 2 store misaligned |
| rspPaddr | output | PA_W | Physical address on a hit |
| missValid | output | 1 | Translation miss pending |
| missVpn | output | VA_W-12 | Virtual page number that missed |
| missType | output | 2 | Access kind that missed |
| fillValid | input | 1 | Write one refill entry |
| fillVpn | input | VA_W-12 | Virtual page number of the refill |
| fillType | input | 2 | Access kind whose tag is written |
| fillBase | input | PA_W-12 | Physical page base of the refill |
| fillDone | input | 1 | Walker finished, repeat the lookup |

## Verification
A corrupted valid bit or tag shows up at the ports within one lookup: either a miss request appears where a hit with a known physical address was expected, or a hit appears where the kind was never filled. The per-kind tests target exactly this by filling one kind and probing the other two. A wrong base update shows as a wrong upper physical address or as kinds that survive a base change. A control slip shows two edges after acceptance, as a missing or doubled response pulse or as a miss request that drops before the done strobe.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } accType_e;

  typedef enum logic [1:0] {
    RSP_HIT         = 2'd0,
    RSP_LD_MISALIGN = 2'd1,
    RSP_ST_MISALIGN = 2'd2
  } rspKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic respond;
  } ctlStrobe_t;

  // lookup outcome from datapath to control
  typedef struct packed {
    logic misalign;
    logic hit;
  } lookStatus_t;

  function automatic accType_e normType(input logic [1:0] raw);
    case (raw)
      2'd0:    return ACC_FETCH;
      2'd2:    return ACC_STORE;
      default: return ACC_LOAD;
    endcase
  endfunction

endpackage

// File: rtl/xlat_ctl.sv
module xlat_ctl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        fillDone,
  input  lookStatus_t status,
  output ctlStrobe_t  strobe,
  output logic        reqReady,
  output logic        missValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MISS} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNext      = ST_LOOK;
      end
      ST_LOOK: begin
        if (status.misalign || status.hit) begin
          strobe.respond = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          stateNext = ST_MISS;
        end
      end
      ST_MISS: if (fillDone) stateNext = ST_LOOK;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign missValid = (state == ST_MISS);

  AST_MISALIGN_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK && status.misalign) |=> (state == ST_IDLE)) else $error("misaligned access went to miss"); // R1
  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && !fillDone) |=> missValid) else $error("miss request dropped early"); // R7
  AST_RETRY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (missValid && fillDone) |=> (state == ST_LOOK)) else $error("no retry after refill"); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> !reqReady) else $error("ready while busy"); // R10

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctlStrobe_t                 strobe,
  input  logic                       flush,
  input  logic [VA_W-1:0]            reqVaddr,
  input  logic [1:0]                 reqSize,
  input  logic [1:0]                 reqType,
  input  logic                       fillValid,
  input  logic [VA_W-PAGE_SHIFT-1:0] fillVpn,
  input  logic [1:0]                 fillType,
  input  logic [PA_W-PAGE_SHIFT-1:0] fillBase,
  output lookStatus_t                status,
  output logic                       rspValid,
  output logic [1:0]                 rspKind,
  output logic [PA_W-1:0]            rspPaddr,
  output logic [VA_W-PAGE_SHIFT-1:0] missVpn,
  output logic [1:0]                 missType
);

  localparam int VPN_W     = VA_W - PAGE_SHIFT;
  localparam int PPN_W     = PA_W - PAGE_SHIFT;
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int NUM_TYPES = 3;

  // captured request
  logic [VA_W-1:0] vaddrQ;
  logic [1:0]      sizeQ;
  accType_e        typeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddrQ <= '0;
      sizeQ  <= '0;
      typeQ  <= ACC_FETCH;
    end else if (strobe.capture) begin
      vaddrQ <= reqVaddr;
      sizeQ  <= reqSize;
      typeQ  <= normType(reqType);
    end
  end

  logic [VPN_W-1:0] vpnQ;
  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] fillIdx;
  accType_e         fillKind;
  assign vpnQ     = vaddrQ[VA_W-1:PAGE_SHIFT];
  assign lookIdx  = vaddrQ[PAGE_SHIFT +: IDX_W];
  assign fillIdx  = fillVpn[IDX_W-1:0];
  assign fillKind = normType(fillType);

  // alignment check for data accesses
  logic [2:0] alignMask;
  always_comb begin
    case (sizeQ)
      2'd0:    alignMask = 3'b000;
      2'd1:    alignMask = 3'b001;
      2'd2:    alignMask = 3'b011;
      default: alignMask = 3'b111;
    endcase
  end
  assign status.misalign = (typeQ != ACC_FETCH) && ((vaddrQ[2:0] & alignMask) != 3'b000);

  // shared page base per slot
  logic [PPN_W-1:0] baseMem [ENTRIES];
  logic [PPN_W-1:0] baseRd;
  logic             baseSame;
  assign baseRd   = baseMem[lookIdx];
  assign baseSame = (baseMem[fillIdx] == fillBase);

  always_ff @(posedge clk) begin
    if (fillValid) baseMem[fillIdx] <= fillBase;
  end

  // per-kind tags and valid bits
  logic [VPN_W-1:0]     tagRd [NUM_TYPES];
  logic [NUM_TYPES-1:0] validRd;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_kind
    logic [VPN_W-1:0]   tagMem [ENTRIES];
    logic [ENTRIES-1:0] validVec;
    logic               fillMine;
    assign fillMine = fillValid && (fillKind == accType_e'(t));

    always_ff @(posedge clk) begin
      if (fillMine) tagMem[fillIdx] <= fillVpn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              validVec <= '0;
      else if (flush)          validVec <= '0;
      else if (fillMine)       validVec[fillIdx] <= 1'b1;
      else if (fillValid && !baseSame) validVec[fillIdx] <= 1'b0;
    end

    assign tagRd[t]   = tagMem[lookIdx];
    assign validRd[t] = validVec[lookIdx];

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (validVec == '0)) else $error("flush left a valid slot"); // R8
  end

  logic [VPN_W-1:0] tagSel;
  logic             validSel;
  always_comb begin
    case (typeQ)
      ACC_FETCH: begin tagSel = tagRd[0]; validSel = validRd[0]; end
      ACC_STORE: begin tagSel = tagRd[2]; validSel = validRd[2]; end
      default:   begin tagSel = tagRd[1]; validSel = validRd[1]; end
    endcase
  end
  assign status.hit = validSel && (tagSel == vpnQ);

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspKind  <= RSP_HIT;
      rspPaddr <= '0;
    end else begin
      rspValid <= strobe.respond;
      if (strobe.respond) begin
        if (status.misalign) begin
          rspKind  <= (typeQ == ACC_STORE) ? RSP_ST_MISALIGN : RSP_LD_MISALIGN;
          rspPaddr <= '0;
        end else begin
          rspKind  <= RSP_HIT;
          rspPaddr <= {baseRd, vaddrQ[PAGE_SHIFT-1:0]};
        end
      end
    end
  end

  assign missVpn  = vpnQ;
  assign missType = typeQ;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid) else $error("response longer than one cycle"); // R10
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspKind == RSP_HIT) |-> (rspPaddr[PAGE_SHIFT-1:0] == vaddrQ[PAGE_SHIFT-1:0]))
    else $error("page offset not carried"); // R4
  AST_STORE_EXC_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspKind != RSP_HIT && typeQ == ACC_STORE) |-> (rspKind == RSP_ST_MISALIGN))
    else $error("store exception of wrong kind"); // R1
  AST_FETCH_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && typeQ == ACC_FETCH) |-> (rspKind == RSP_HIT))
    else $error("fetch raised misalignment"); // R2

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [VA_W-1:0]            reqVaddr,
  input  logic [1:0]                 reqSize,
  input  logic [1:0]                 reqType,
  output logic                       rspValid,
  output logic [1:0]                 rspKind,
  output logic [PA_W-1:0]            rspPaddr,
  output logic                       missValid,
  output logic [VA_W-PAGE_SHIFT-1:0] missVpn,
  output logic [1:0]                 missType,
  input  logic                       fillValid,
  input  logic [VA_W-PAGE_SHIFT-1:0] fillVpn,
  input  logic [1:0]                 fillType,
  input  logic [PA_W-PAGE_SHIFT-1:0] fillBase,
  input  logic                       fillDone
);

  ctlStrobe_t  strobe;
  lookStatus_t status;

  xlat_ctl ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .fillDone  (fillDone),
    .status    (status),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .missValid (missValid)
  );

  xlat_dp #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ENTRIES    (ENTRIES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .flush     (flush),
    .reqVaddr  (reqVaddr),
    .reqSize   (reqSize),
    .reqType   (reqType),
    .fillValid (fillValid),
    .fillVpn   (fillVpn),
    .fillType  (fillType),
    .fillBase  (fillBase),
    .status    (status),
    .rspValid  (rspValid),
    .rspKind   (rspKind),
    .rspPaddr  (rspPaddr),
    .missVpn   (missVpn),
    .missType  (missType)
  );

endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;

  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int PS   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [VA_W-1:0] reqVaddr = '0;
  logic [1:0] reqSize = '0;
  logic [1:0] reqType = '0;
  logic rspValid;
  logic [1:0] rspKind;
  logic [PA_W-1:0] rspPaddr;
  logic missValid;
  logic [VA_W-PS-1:0] missVpn;
  logic [1:0] missType;
  logic fillValid = 1'b0;
  logic [VA_W-PS-1:0] fillVpn = '0;
  logic [1:0] fillType = '0;
  logic [PA_W-PS-1:0] fillBase = '0;
  logic fillDone = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqSize(reqSize), .reqType(reqType),
    .rspValid(rspValid), .rspKind(rspKind), .rspPaddr(rspPaddr),
    .missValid(missValid), .missVpn(missVpn), .missType(missType),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillType(fillType),
    .fillBase(fillBase), .fillDone(fillDone)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic flushAll();
    @(negedge clk) flush = 1'b1;
    @(posedge clk);
    @(negedge clk) flush = 1'b0;
  endtask

  task automatic preload(input logic [VA_W-PS-1:0] vpn, input logic [1:0] kind, input logic [PA_W-PS-1:0] base);
    @(negedge clk);
    fillValid = 1'b1; fillVpn = vpn; fillType = kind; fillBase = base;
    @(posedge clk);
    @(negedge clk) fillValid = 1'b0;
  endtask

  // issue one request; sample two edges after acceptance
  task automatic runReq(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic [1:0] kind,
                        output bit gotRsp, output bit gotMiss);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqSize = sz; reqType = kind;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10 busy after accept", reqReady, 0);
    @(posedge clk);
    @(negedge clk);
    gotRsp  = rspValid;
    gotMiss = missValid;
  endtask

  task automatic expectHit(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic [1:0] kind,
                           input logic [PA_W-PS-1:0] base, input string req);
    bit r, m;
    runReq(va, sz, kind, r, m);
    check(r && !m, req, {r, m}, 2'b10);
    check(rspKind == 2'd0, req, rspKind, 0);
    check(rspPaddr == {base, va[PS-1:0]}, req, rspPaddr, {base, va[PS-1:0]});
    @(negedge clk);
    check(rspValid == 1'b0, "R10 one-cycle pulse", rspValid, 0);
  endtask

  task automatic expectExc(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic [1:0] kind,
                           input logic [1:0] expKind, input string req);
    bit r, m;
    runReq(va, sz, kind, r, m);
    check(r && !m, req, {r, m}, 2'b10);
    check(rspKind == expKind, req, rspKind, expKind);
    @(negedge clk);
    check(missValid == 1'b0, req, missValid, 0);
  endtask

  // expect a miss, hold it, then serve it with the given base and expect the retried hit
  task automatic expectMiss(input logic [VA_W-1:0] va, input logic [1:0] sz, input logic [1:0] kind,
                            input logic [PA_W-PS-1:0] base, input int holdCycles, input string req);
    bit r, m;
    logic [1:0] expType;
    expType = (kind == 2'd3) ? 2'd1 : kind;
    runReq(va, sz, kind, r, m);
    check(m && !r, req, {r, m}, 2'b01);
    check(missVpn == va[VA_W-1:PS], req, missVpn, va[VA_W-1:PS]);
    check(missType == expType, req, missType, expType);
    for (int i = 0; i < holdCycles; i++) begin
      @(negedge clk);
      check(missValid && missVpn == va[VA_W-1:PS] && missType == expType,
            "R7 miss held", {missValid, missType}, {1'b1, expType});
    end
    @(negedge clk);
    fillValid = 1'b1; fillVpn = missVpn; fillType = missType; fillBase = base; fillDone = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fillValid = 1'b0; fillDone = 1'b0;
    check(rspValid == 1'b0, "R7 no early response", rspValid, 0);
    @(posedge clk);
    @(negedge clk);
    check(rspValid && rspKind == 2'd0, "R7 retry hits", {rspValid, rspKind}, 3'b100);
    check(rspPaddr == {base, va[PS-1:0]}, "R7 retry paddr", rspPaddr, {base, va[PS-1:0]});
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R9 ready", reqReady, 1);
    check(rspValid == 1'b0, "R9 no rsp", rspValid, 0);
    check(missValid == 1'b0, "R9 no miss", missValid, 0);
    expectMiss(32'h0000_5000, 2'd2, 2'd1, 20'h00AAA, 0, "R9 empty after reset");
  endtask

  task automatic testMisalign();
    flushAll();
    expectExc(32'h0001_2002, 2'd2, 2'd1, 2'd1, "R1 load word misaligned");
    expectExc(32'h0001_2001, 2'd1, 2'd2, 2'd2, "R1 store half misaligned");
    expectExc(32'h0001_2004, 2'd3, 2'd1, 2'd1, "R1 load double misaligned");
    expectExc(32'h0001_2003, 2'd2, 2'd3, 2'd1, "R2 type 3 as load");
    preload(20'h00012, 2'd1, 20'h00345);
    expectHit(32'h0001_2008, 2'd3, 2'd1, 20'h00345, "R1 aligned double");
    expectHit(32'h0001_2007, 2'd0, 2'd1, 20'h00345, "R1 byte any address");
    preload(20'h00012, 2'd0, 20'h00345);
    expectHit(32'h0001_2003, 2'd3, 2'd0, 20'h00345, "R2 fetch unchecked");
  endtask

  task automatic testKinds();
    flushAll();
    preload(20'h12345, 2'd1, 20'hABCDE);
    expectHit(32'h1234_5678, 2'd2, 2'd1, 20'hABCDE, "R4 load hit paddr");
    expectMiss(32'h1234_5678, 2'd2, 2'd2, 20'hABCDE, 0, "R5 store separate");
    expectMiss(32'h1234_567C, 2'd2, 2'd0, 20'hABCDE, 0, "R5 fetch separate");
    expectHit(32'h1234_5000, 2'd3, 2'd1, 20'hABCDE, "R6 same base keeps load");
    expectMiss(32'h1244_5678, 2'd2, 2'd1, 20'h11111, 0, "R3 alias 256 pages apart");
    expectMiss(32'h1234_5678, 2'd2, 2'd1, 20'hABCDE, 0, "R3 alias evicted");
  endtask

  task automatic testBaseChange();
    flushAll();
    preload(20'h00777, 2'd1, 20'h00100);
    preload(20'h00777, 2'd2, 20'h00100);
    expectHit(32'h0077_7010, 2'd2, 2'd2, 20'h00100, "R6 store same base");
    expectHit(32'h0077_7010, 2'd2, 2'd1, 20'h00100, "R6 load kept");
    preload(20'h00777, 2'd0, 20'h00200);
    expectHit(32'h0077_7020, 2'd2, 2'd0, 20'h00200, "R6 fetch new base");
    expectMiss(32'h0077_7030, 2'd2, 2'd1, 20'h00200, 0, "R6 load dropped");
    expectMiss(32'h0077_7040, 2'd2, 2'd2, 20'h00200, 0, "R6 store dropped");
  endtask

  task automatic testMissHold();
    flushAll();
    expectMiss(32'h0ABC_D124, 2'd2, 2'd2, 20'h0F0F0, 4, "R7 miss request");
    expectHit(32'h0ABC_D128, 2'd2, 2'd2, 20'h0F0F0, "R7 filled entry stays");
  endtask

  task automatic testFlush();
    flushAll();
    preload(20'h00033, 2'd0, 20'h00055);
    preload(20'h00033, 2'd1, 20'h00055);
    expectHit(32'h0003_3000, 2'd2, 2'd0, 20'h00055, "R8 before flush");
    flushAll();
    expectMiss(32'h0003_3000, 2'd2, 2'd0, 20'h00066, 0, "R8 fetch gone");
    expectMiss(32'h0003_3004, 2'd2, 2'd1, 20'h00066, 0, "R8 load gone");
    // flush and refill in the same cycle: flush wins
    @(negedge clk);
    flush = 1'b1; fillValid = 1'b1; fillVpn = 20'h00044; fillType = 2'd1; fillBase = 20'h00077;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0; fillValid = 1'b0;
    expectMiss(32'h0004_4000, 2'd2, 2'd1, 20'h00077, 0, "R8 flush beats refill");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    testReset();
    testMisalign();
    testKinds();
    testBaseChange();
    testMissHold();
    testFlush();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule